// File: doc/BRIEF.md
# Paired-Access Circulant Message Store

This block holds the soft messages that belong to one cyclically shifted identity sub-matrix of a quasi-cyclic LDPC parity-check matrix. A decoder sweeps the store in row order during one phase and in column order during the other, and it wants two neighbouring messages in every cycle in both sweeps. The shift value is left unrestricted. Entries are kept in row order and split by index parity into an even sub-bank and an odd sub-bank. Two neighbouring indices always have opposite parity, so a pair is normally served by both sub-banks at once.

A pulse on `start` launches one sweep of all `N` entries. In row mode the sweep begins at entry 0. In column mode it begins at `shift` reduced modulo `N`. A counter steps the index by two and wraps modulo `N`. A lane swap places the symbol that comes first in sweep order on lane 0. `N` is an odd prime, so two cases need care. The sweep may reach the pair (N-1, 0), where both indices are even. That pair is split over two cycles and `stall` is raised in the first of them. A sweep of odd length also ends with a single symbol. Reads have one cycle of latency. The two write lanes let processed messages be written back while a sweep is reading.

Top module: `circ_pair_mem`

## Requirements
- R1: After reset, `busy`, `stall`, `acc_v0`, `acc_v1`, `rd_v0` and `rd_v1` are all 0.
- R2: A `start` pulse while idle launches a sweep. With `col_mode`=0 the sweep begins at entry 0 and `shift` has no effect.
- R3: With `col_mode`=1 the sweep begins at entry `shift` mod `N`. A `shift` of `N` or more is reduced to its remainder.
- R4: A sweep delivers each of the `N` entries exactly once, in the cyclic order start, start+1, ... (mod `N`). Within a cycle, lane 0 comes before lane 1 in that order.
- R5: When both access lanes are valid, `acc_idx1` equals `acc_idx0`+1 and the two indices have opposite parity (bit 0 differs).
- R6: The pair (N-1, 0) takes two cycles. In the first cycle only lane 0 is valid, with index N-1, and `stall`=1. In the second cycle only lane 1 is valid, with index 0. A sweep takes (N+1)/2 access cycles, plus one more when this pair occurs.
- R7: When one symbol is left at the end of a sweep, it is issued alone on lane 0 and the sweep ends (`busy` falls).
- R8: Read data for an access cycle appears on the same lane, with `rd_v0`/`rd_v1` set, in the following cycle.
- R9: A write to an entry that is read in the same cycle returns the old contents to that read. Later sweeps return the new value.
- R10: If both write lanes target the same sub-bank (same index parity), only lane 0 is written and lane 1 is dropped.
- R11: A `start` pulse while `busy`=1 is ignored. The running sweep continues unchanged and no new sweep follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a sweep (taken only when idle) |
| col_mode | input | 1 | 0 = row sweep from entry 0, 1 = column sweep from shift |
| shift | input | IW | Circulant shift value, reduced mod N |
| busy | output | 1 | Sweep in progress |
| stall | output | 1 | First half of a split wrap pair |
| acc_v0 | output | 1 | Lane 0 access valid this cycle |
| acc_idx0 | output | IW | Lane 0 entry index |
| acc_v1 | output | 1 | Lane 1 access valid this cycle |
| acc_idx1 | output | IW | Lane 1 entry index |
| wr_en0 | input | 1 | Write lane 0 enable (priority lane) |
| wr_idx0 | input | IW | Write lane 0 entry index |
| wr_data0 | input | W | Write lane 0 data |
| wr_en1 | input | 1 | Write lane 1 enable |
| wr_idx1 | input | IW | Write lane 1 entry index |
| wr_data1 | input | W | Write lane 1 data |
| rd_v0 | output | 1 | Lane 0 read data valid |
| rd_data0 | output | W | Lane 0 read data |
| rd_v1 | output | 1 | Lane 1 read data valid |
| rd_data1 | output | W | Lane 1 read data |

## Verification
The sweep is tried in row mode with a nonzero shift that must be ignored, and in column mode with every shift from 0 to N. Odd starting points show that the lane swap keeps sweep order. Nonzero even starting points must produce exactly one split wrap pair and a stall. Zero and N separate plain sweeps from reduced shifts. The memory is filled with swapped write lanes so that write routing by parity is covered. Directed cases cover a write that lands on the entry being read in the same cycle, two writes aimed at one sub-bank, and a second start issued in the middle of a sweep.

// File: rtl/circ_pkg.sv
package circ_pkg;

    typedef enum logic [1:0] {
        GS_IDLE,
        GS_RUN,
        GS_SPLIT
    } gen_state_e;

    typedef struct packed {
        logic v0;
        logic v1;
        logic swap;
        logic stall;
    } lane_ctl_t;

    // a + inc reduced once modulo n (valid while a + inc < 2n)
    function automatic int unsigned wrap_inc(int unsigned a, int unsigned inc, int unsigned n);
        int unsigned t;
        t = a + inc;
        return (t >= n) ? t - n : t;
    endfunction

endpackage

// File: rtl/circ_addr_gen.sv
module circ_addr_gen
    import circ_pkg::*;
#(
    parameter int N  = 7,
    parameter int IW = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            col_mode,
    input  logic [IW-1:0]   shift,
    output logic            busy,
    output logic [IW-1:0]   idx0,
    output logic [IW-1:0]   idx1,
    output lane_ctl_t       ctl
);
    localparam int CW = $clog2(N + 1);
    localparam logic [IW-1:0] LAST = IW'(N - 1);
    localparam logic [CW-1:0] FULL = CW'(N);

    gen_state_e      st;
    logic [IW-1:0]   cur;
    logic [CW-1:0]   rem;
    logic            single;
    logic            at_last;

    assign single  = (rem == CW'(1));
    assign at_last = (cur == LAST);
    assign busy    = (st != GS_IDLE);

    always_comb begin
        idx0 = cur;
        idx1 = IW'(wrap_inc(32'(cur), 1, N));
        ctl  = '0;
        unique case (st)
            GS_RUN: begin
                ctl.v0   = 1'b1;
                ctl.swap = cur[0];
                if (single) begin
                    ctl.v1 = 1'b0;
                end else if (at_last) begin
                    ctl.stall = 1'b1;
                end else begin
                    ctl.v1 = 1'b1;
                end
            end
            GS_SPLIT: begin
                idx0     = LAST;
                idx1     = '0;
                ctl.v1   = 1'b1;
                ctl.swap = 1'b1;
            end
            default: ctl = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= GS_IDLE;
            cur <= '0;
            rem <= '0;
        end else begin
            unique case (st)
                GS_IDLE: begin
                    if (start) begin
                        st  <= GS_RUN;
                        cur <= col_mode ? IW'(wrap_inc(32'(shift), 0, N)) : '0;
                        rem <= FULL;
                    end
                end
                GS_RUN: begin
                    if (single) begin
                        st <= GS_IDLE;
                    end else if (at_last) begin
                        st  <= GS_SPLIT;
                        rem <= rem - CW'(1);
                    end else begin
                        cur <= IW'(wrap_inc(32'(cur), 2, N));
                        rem <= rem - CW'(2);
                        if (rem == CW'(2)) st <= GS_IDLE;
                    end
                end
                GS_SPLIT: begin
                    cur <= IW'(1);
                    rem <= rem - CW'(1);
                    st  <= single ? GS_IDLE : GS_RUN;
                end
                default: st <= GS_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/circ_subbank.sv
module circ_subbank #(
    parameter int AW = 2,
    parameter int W  = 6
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] mem [DEPTH];

    // read returns the pre-write contents on a same-address collision
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        if (re) rdata <= mem[raddr];
    end

endmodule

// File: rtl/circ_pair_mem.sv
module circ_pair_mem
    import circ_pkg::*;
#(
    parameter int N  = 7,
    parameter int W  = 6,
    parameter int IW = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            col_mode,
    input  logic [IW-1:0]   shift,
    output logic            busy,
    output logic            stall,
    output logic            acc_v0,
    output logic [IW-1:0]   acc_idx0,
    output logic            acc_v1,
    output logic [IW-1:0]   acc_idx1,
    input  logic            wr_en0,
    input  logic [IW-1:0]   wr_idx0,
    input  logic [W-1:0]    wr_data0,
    input  logic            wr_en1,
    input  logic [IW-1:0]   wr_idx1,
    input  logic [W-1:0]    wr_data1,
    output logic            rd_v0,
    output logic [W-1:0]    rd_data0,
    output logic            rd_v1,
    output logic [W-1:0]    rd_data1
);
    localparam int AW = IW - 1;

    lane_ctl_t       ctl;
    logic            rv0_q, rv1_q, swap_q;

    logic            bank_re [2];
    logic            bank_we [2];
    logic [AW-1:0]   bank_ra [2];
    logic [AW-1:0]   bank_wa [2];
    logic [W-1:0]    bank_wd [2];
    logic [W-1:0]    bank_rd [2];

    circ_addr_gen #(.N(N), .IW(IW)) u_gen (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .col_mode (col_mode),
        .shift    (shift),
        .busy     (busy),
        .idx0     (acc_idx0),
        .idx1     (acc_idx1),
        .ctl      (ctl)
    );

    assign acc_v0 = ctl.v0;
    assign acc_v1 = ctl.v1;
    assign stall  = ctl.stall;

    // read swap: bank 0 holds even entries, bank 1 odd entries
    always_comb begin
        bank_re[0] = ctl.swap ? ctl.v1 : ctl.v0;
        bank_re[1] = ctl.swap ? ctl.v0 : ctl.v1;
        bank_ra[0] = ctl.swap ? acc_idx1[IW-1:1] : acc_idx0[IW-1:1];
        bank_ra[1] = ctl.swap ? acc_idx0[IW-1:1] : acc_idx1[IW-1:1];
    end

    // write steering by index parity, lane 0 first
    always_comb begin
        for (int p = 0; p < 2; p++) begin
            bank_we[p] = 1'b0;
            bank_wa[p] = wr_idx0[IW-1:1];
            bank_wd[p] = wr_data0;
            if (wr_en0 && (wr_idx0[0] == 1'(p))) begin
                bank_we[p] = 1'b1;
            end else if (wr_en1 && (wr_idx1[0] == 1'(p))) begin
                bank_we[p] = 1'b1;
                bank_wa[p] = wr_idx1[IW-1:1];
                bank_wd[p] = wr_data1;
            end
        end
    end

    for (genvar p = 0; p < 2; p++) begin : g_bank
        circ_subbank #(.AW(AW), .W(W)) u_bank (
            .clk   (clk),
            .we    (bank_we[p]),
            .waddr (bank_wa[p]),
            .wdata (bank_wd[p]),
            .re    (bank_re[p]),
            .raddr (bank_ra[p]),
            .rdata (bank_rd[p])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rv0_q  <= 1'b0;
            rv1_q  <= 1'b0;
            swap_q <= 1'b0;
        end else begin
            rv0_q  <= ctl.v0;
            rv1_q  <= ctl.v1;
            swap_q <= ctl.swap;
        end
    end

    assign rd_v0    = rv0_q;
    assign rd_v1    = rv1_q;
    assign rd_data0 = swap_q ? bank_rd[1] : bank_rd[0];
    assign rd_data1 = swap_q ? bank_rd[0] : bank_rd[1];

endmodule

// File: rtl/circ_pair_mem_chk.sv
module circ_pair_mem_chk #(
    parameter int N  = 7,
    parameter int IW = $clog2(N)
) (
    input logic          clk,
    input logic          rst,
    input logic          busy,
    input logic          stall,
    input logic          acc_v0,
    input logic [IW-1:0] acc_idx0,
    input logic          acc_v1,
    input logic [IW-1:0] acc_idx1,
    input logic          rd_v0,
    input logic          rd_v1
);
    localparam logic [IW-1:0] LAST = IW'(N - 1);

    AST_PAIR_ADJACENT: assert property (@(posedge clk) disable iff (rst)
        (acc_v0 && acc_v1) |-> (acc_idx0 != LAST) && (acc_idx1 == acc_idx0 + IW'(1))); // R5
    AST_PAIR_PARITY: assert property (@(posedge clk) disable iff (rst)
        (acc_v0 && acc_v1) |-> (acc_idx0[0] != acc_idx1[0])); // R5
    AST_STALL_SHAPE: assert property (@(posedge clk) disable iff (rst)
        stall |-> acc_v0 && !acc_v1 && (acc_idx0 == LAST)); // R6
    AST_STALL_SECOND: assert property (@(posedge clk) disable iff (rst)
        stall |=> !acc_v0 && acc_v1 && (acc_idx1 == '0)); // R6
    AST_RD_LANE0: assert property (@(posedge clk) disable iff (rst)
        acc_v0 |=> rd_v0); // R8
    AST_RD_LANE1: assert property (@(posedge clk) disable iff (rst)
        acc_v1 |=> rd_v1); // R8
    AST_RD_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!acc_v0 && !acc_v1) |=> (!rd_v0 && !rd_v1)); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!acc_v0 && !acc_v1 && !stall)); // R1

endmodule

bind circ_pair_mem circ_pair_mem_chk #(.N(N), .IW(IW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .stall    (stall),
    .acc_v0   (acc_v0),
    .acc_idx0 (acc_idx0),
    .acc_v1   (acc_v1),
    .acc_idx1 (acc_idx1),
    .rd_v0    (rd_v0),
    .rd_v1    (rd_v1)
);

// File: tb/circ_pair_mem_bench.sv
`timescale 1ns/1ps
module circ_pair_mem_bench;
    localparam int N  = 7;
    localparam int W  = 6;
    localparam int IW = 3;
    localparam int NV = 9;
    // sweep vectors: mode, shift, expected access cycles
    localparam int VMODE [NV] = '{0, 1, 1, 1, 1, 1, 1, 1, 1};
    localparam int VSHIFT[NV] = '{5, 0, 1, 2, 3, 4, 5, 6, 7};
    localparam int VCYC  [NV] = '{4, 4, 4, 5, 4, 5, 4, 5, 4};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0, col_mode = 1'b0;
    logic [IW-1:0] shift = '0;
    logic busy, stall, acc_v0, acc_v1, rd_v0, rd_v1;
    logic [IW-1:0] acc_idx0, acc_idx1;
    logic wr_en0 = 1'b0, wr_en1 = 1'b0;
    logic [IW-1:0] wr_idx0 = '0, wr_idx1 = '0;
    logic [W-1:0] wr_data0 = '0, wr_data1 = '0;
    logic [W-1:0] rd_data0, rd_data1;

    int checks = 0;
    int errors = 0;
    logic [W-1:0] model [N];
    logic [W-1:0] got [16];
    int p_cyc, p_stl, p_cnt;
    logic inj_start = 1'b0;
    logic do_rdw = 1'b0;

    always #4 clk = ~clk;

    circ_pair_mem #(.N(N), .W(W), .IW(IW)) u_circ_pair_mem (
        .clk(clk), .rst(rst), .start(start), .col_mode(col_mode), .shift(shift),
        .busy(busy), .stall(stall),
        .acc_v0(acc_v0), .acc_idx0(acc_idx0), .acc_v1(acc_v1), .acc_idx1(acc_idx1),
        .wr_en0(wr_en0), .wr_idx0(wr_idx0), .wr_data0(wr_data0),
        .wr_en1(wr_en1), .wr_idx1(wr_idx1), .wr_data1(wr_data1),
        .rd_v0(rd_v0), .rd_data0(rd_data0), .rd_v1(rd_v1), .rd_data1(rd_data1)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_pass(input logic m, input logic [IW-1:0] sh);
        col_mode = m;
        shift = sh;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        p_cyc = 0; p_stl = 0; p_cnt = 0;
        for (int k = 0; k < 12; k++) begin
            if (acc_v0 || acc_v1) p_cyc++;
            if (stall) p_stl++;
            if (rd_v0 && p_cnt < 16) begin got[p_cnt] = rd_data0; p_cnt++; end
            if (rd_v1 && p_cnt < 16) begin got[p_cnt] = rd_data1; p_cnt++; end
            if (k == 1 && inj_start) begin
                start = 1'b1; col_mode = 1'b1; shift = 3'd2;
            end else begin
                start = 1'b0;
            end
            if (k == 0 && do_rdw) begin
                wr_en0 = 1'b1; wr_idx0 = acc_idx0; wr_data0 = 6'd60;
                wr_en1 = 1'b1; wr_idx1 = acc_idx1; wr_data1 = 6'd61;
            end else begin
                wr_en0 = 1'b0; wr_en1 = 1'b0;
            end
            @(negedge clk);
        end
    endtask

    task automatic check_stream(input int s, input string req);
        check(p_cnt == N, req, p_cnt, N);
        for (int k = 0; k < N; k++) begin
            if (k < p_cnt)
                check(got[k] == model[(s + k) % N], req, int'(got[k]), int'(model[(s + k) % N]));
        end
    endtask

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check(!busy && !stall && !acc_v0 && !acc_v1 && !rd_v0 && !rd_v1, "R1",
              int'({busy, stall, acc_v0, acc_v1, rd_v0, rd_v1}), 0);

        // fill with lanes swapped (odd index on lane 0)
        for (int k = 0; k < N; k++) model[k] = W'((k * 5 + 3) % 64);
        for (int k = 0; k < N - 1; k += 2) begin
            wr_en0 = 1'b1; wr_idx0 = IW'(k + 1); wr_data0 = model[k + 1];
            wr_en1 = 1'b1; wr_idx1 = IW'(k);     wr_data1 = model[k];
            @(negedge clk);
        end
        wr_en0 = 1'b0;
        wr_en1 = 1'b1; wr_idx1 = IW'(N - 1); wr_data1 = model[N - 1];
        @(negedge clk);
        wr_en1 = 1'b0;

        // table of sweeps: R2 R3 R4 R6 R7 R8
        for (int v = 0; v < NV; v++) begin
            int s;
            s = (VMODE[v] == 0) ? 0 : (VSHIFT[v] % N);
            run_pass(VMODE[v][0], IW'(VSHIFT[v]));
            check_stream(s, (VMODE[v] == 0) ? "R2 R4 R8 row sweep" : "R3 R4 R8 column sweep");
            check(p_cyc == VCYC[v], "R6 R7 access cycles", p_cyc, VCYC[v]);
            check(p_stl == ((VCYC[v] == 5) ? 1 : 0), "R6 stall count", p_stl, (VCYC[v] == 5) ? 1 : 0);
            check(!busy, "R7 sweep ended", int'(busy), 0);
        end

        // R9 write into the pair being read
        do_rdw = 1'b1;
        run_pass(1'b0, '0);
        do_rdw = 1'b0;
        check_stream(0, "R9 old data on collision");
        model[0] = 6'd60; model[1] = 6'd61;
        run_pass(1'b0, '0);
        check_stream(0, "R9 new data later");

        // R10 both write lanes to the even sub-bank
        wr_en0 = 1'b1; wr_idx0 = 3'd2; wr_data0 = 6'd50;
        wr_en1 = 1'b1; wr_idx1 = 3'd4; wr_data1 = 6'd51;
        @(negedge clk);
        wr_en0 = 1'b0; wr_en1 = 1'b0;
        model[2] = 6'd50;
        run_pass(1'b0, '0);
        check_stream(0, "R10 lane 0 wins");
        check(got[4] == model[4], "R10 lane 1 dropped", int'(got[4]), int'(model[4]));

        // R11 start during a sweep
        inj_start = 1'b1;
        run_pass(1'b1, 3'd3);
        inj_start = 1'b0;
        check_stream(3, "R11 sweep unchanged");
        check(p_cyc == 4 && p_stl == 0, "R11 no restart", p_cyc, 4);
        check(!busy && !acc_v0 && !acc_v1, "R11 idle after", int'(busy), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule